// File: doc/BRIEF.md
# Test Coprocessor with Stall and Delayed Interrupt Scheduling

This block is a small coprocessor meant for processor test programs. It holds sixteen 32-bit general registers. A program can stall itself for a number of cycles that it has put in one of those registers. It can also arrange for the fast or the normal interrupt line to go low after a programmed delay, raise either line again, or copy a free-running cycle count into a register.

The host decodes the instruction and answers for two coprocessor numbers. Both numbers behave the same way for register transfers, so that port carries no number select. The host passes in the instruction fields the block needs:
- the transfer register index, taken from instruction bits 19:16;
- the load/store register index, taken from bits 15:12;
- the operation code, taken from bits 23:20;
- the source register index, taken from bits 3:0.

The register-transfer and load/store ports follow valid/ready rules. The block never applies back-pressure: `rt_ready` and `ls_ready` are tied high, so every beat presented with valid is taken in the cycle it is presented. Read data is combinational and belongs to the beat that is presented in that same cycle.

The data-operation port is a level handshake. The host holds `dp_valid`, the operation code and the source index steady. It samples `dp_resp` every cycle until it sees done or cannot, then drops `dp_valid` for at least one cycle. A one-cycle pulse of `dp_valid` issues exactly one non-wait operation.

Top module: `test_copro`

## Requirements
- R1: After reset all sixteen registers read zero, `fiq_n` and `irq_n` are high, `dp_resp` reads idle (3) with no operation presented, and no stall is in progress.
- R2: A register-transfer beat with `rt_write`=1 stores `rt_wdata` into register `rt_idx` at the clock edge. With `rt_write`=0, `rt_rdata` shows register `rt_idx` in the same cycle.
- R3: Load/store works only for the first number (`ls_cp`=0). A load (`ls_store`=0) writes register `ls_idx`+beat and a store shows that register on `ls_rdata`. With `ls_long`=1 the first beat uses `ls_idx` and the second uses `ls_idx`+1 modulo 16. A single beat resets the beat position to 0. A beat with `ls_cp`=1 raises `ls_cant` and changes no register.
- R4: Operation 0 on either number stalls. With N taken from register `dp_src` at the first cycle, `dp_resp` is busy (1) for N cycles and then done (0). When N is zero, `dp_resp` is done in the first cycle.
- R5: For the first number (`dp_cp`=0), any operation code other than 0 answers cannot (2). For the second number (`dp_cp`=1), any code above 5 answers cannot. Such a request changes no register and no interrupt line.
- R6: Operation 1 (FIQ) or 2 (IRQ) on the second number, with delay D read from register `dp_src`, drives that line low starting D+1 cycles after the issue cycle. The line then stays low until it is cleared. With D=0 the line is low in the very next cycle.
- R7: A new schedule for a line replaces any schedule still pending on that line; only the new delay counts.
- R8: Operation 3 raises `fiq_n` and operation 4 raises `irq_n` in the next cycle. Each also cancels any pending schedule for its line.
- R9: Operation 5 writes the current cycle count into register `dp_src`.
- R10: The cycle count is 0 in the first cycle after reset is released. It grows by one every cycle and wraps modulo 2^32.
- R11: When several writes target one register in the same cycle, the capture of operation 5 wins over a register-transfer write, and a register-transfer write wins over a load.
- R12: `dp_resp` encodes done as 0, busy as 1, cannot as 2, and idle as 3. Idle is shown whenever `dp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_valid | input | 1 | Register-transfer beat present |
| rt_ready | output | 1 | Always high; a transfer is never stalled |
| rt_write | input | 1 | 1 writes the register, 0 reads it |
| rt_idx | input | 4 | Register index (instruction bits 19:16) |
| rt_wdata | input | 32 | Write data |
| rt_rdata | output | 32 | Read data for `rt_idx` |
| ls_valid | input | 1 | Load/store beat present |
| ls_ready | output | 1 | Always high |
| ls_cp | input | 1 | 0 first coprocessor number, 1 second |
| ls_store | input | 1 | 1 store (register to host), 0 load |
| ls_long | input | 1 | Beat belongs to a two-word transfer |
| ls_idx | input | 4 | Base register index (instruction bits 15:12) |
| ls_wdata | input | 32 | Load data |
| ls_rdata | output | 32 | Store data |
| ls_cant | output | 1 | Beat rejected (second number) |
| dp_valid | input | 1 | Data operation presented |
| dp_cp | input | 1 | 0 first number, 1 second |
| dp_op | input | 4 | Operation code (instruction bits 23:20) |
| dp_src | input | 4 | Source/target register (instruction bits 3:0) |
| dp_resp | output | 2 | 0 done, 1 busy, 2 cannot, 3 idle |
| fiq_n | output | 1 | Active-low fast interrupt |
| irq_n | output | 1 | Active-low normal interrupt |

## Verification
The stall is tried with counts of zero, one and five, on both numbers. These runs separate an immediate done, a one-cycle stall, and an off-by-one in the count.

Interrupt scheduling is tried in five patterns:
- a plain delay;
- a zero delay;
- a long delay overtaken by a short one;
- a pending delay cancelled by a clear;
- both lines active at once.

Together these separate replacement, cancellation and the exact cycle of assertion.

Same-cycle writes from all three sources to one register expose the write priority. Two captures a known distance apart expose the counter step.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  typedef enum logic [1:0] {
    RSP_DONE = 2'd0,
    RSP_BUSY = 2'd1,
    RSP_CANT = 2'd2,
    RSP_IDLE = 2'd3
  } rsp_e;

  localparam logic [3:0] OP_STALL   = 4'd0;
  localparam logic [3:0] OP_FIQ_SET = 4'd1;
  localparam logic [3:0] OP_IRQ_SET = 4'd2;
  localparam logic [3:0] OP_FIQ_CLR = 4'd3;
  localparam logic [3:0] OP_IRQ_CLR = 4'd4;
  localparam logic [3:0] OP_STAMP   = 4'd5;
  localparam logic [3:0] OP_LAST    = OP_STAMP;
endpackage

// File: rtl/tcp_regfile.sv
module tcp_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [AW-1:0] idx_a,
  input  logic [DW-1:0] d_a,
  input  logic          we_b,
  input  logic [AW-1:0] idx_b,
  input  logic [DW-1:0] d_b,
  input  logic          we_c,
  input  logic [AW-1:0] idx_c,
  input  logic [DW-1:0] d_c,
  input  logic [AW-1:0] rd_idx0,
  output logic [DW-1:0] rd_dat0,
  input  logic [AW-1:0] rd_idx1,
  output logic [DW-1:0] rd_dat1,
  input  logic [AW-1:0] rd_idx2,
  output logic [DW-1:0] rd_dat2
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_row
    localparam logic [AW-1:0] ME = AW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n)                    mem[i] <= '0;
      else if (we_a && idx_a == ME)  mem[i] <= d_a;
      else if (we_b && idx_b == ME)  mem[i] <= d_b;
      else if (we_c && idx_c == ME)  mem[i] <= d_c;
    end
  end

  assign rd_dat0 = mem[rd_idx0];
  assign rd_dat1 = mem[rd_idx1];
  assign rd_dat2 = mem[rd_idx2];

  // R11: the top-priority write always lands
  assert_prio_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
    we_a |=> mem[$past(idx_a)] == $past(d_a));
endmodule

// File: rtl/tcp_stall.sv
module tcp_stall #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [CW-1:0] count,
  output logic          busy,
  output logic          active
);
  logic          active_q;
  logic [CW-1:0] rem_q;

  assign busy   = req && (active_q ? (rem_q != '0) : (count != '0));
  assign active = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rem_q    <= '0;
    end else if (!req) begin
      active_q <= 1'b0;
    end else if (!active_q) begin
      if (count != '0) begin
        active_q <= 1'b1;
        rem_q    <= count - 1'b1;
      end
    end else if (rem_q == '0) begin
      active_q <= 1'b0;
    end else begin
      rem_q <= rem_q - 1'b1;
    end
  end

  // R4: a stall only starts on a nonzero count
  assert_start_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(count != '0));
  // R4: after a done answer the stall is over
  assert_done_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && active_q && !busy) |=> !active_q);
endmodule

// File: rtl/tcp_line_sched.sv
module tcp_line_sched #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched,
  input  logic          clr,
  input  logic [CW-1:0] delay,
  output logic          line_n
);
  logic          pend_q;
  logic [CW-1:0] left_q;
  logic          line_q;

  assign line_n = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      left_q <= '0;
      line_q <= 1'b1;
    end else if (clr) begin
      pend_q <= 1'b0;
      line_q <= 1'b1;
    end else if (sched) begin
      if (delay == '0) begin
        pend_q <= 1'b0;
        line_q <= 1'b0;
      end else begin
        pend_q <= 1'b1;
        left_q <= delay - 1'b1;
      end
    end else if (pend_q) begin
      if (left_q == '0) begin
        pend_q <= 1'b0;
        line_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  // R6: the line only falls from a schedule
  assert_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_q) |-> $past(pend_q || sched));
  // R8: a clear always leaves the line high
  assert_clear_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> line_q);
endmodule

// File: rtl/tcp_cycle_ctr.sv
module tcp_cycle_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      run_q <= 1'b1;
    end
  end

  assign count = cnt_q;

  // R10: steady single-step progress
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/test_copro.sv
module test_copro #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rt_valid,
  output logic          rt_ready,
  input  logic          rt_write,
  input  logic [AW-1:0] rt_idx,
  input  logic [DW-1:0] rt_wdata,
  output logic [DW-1:0] rt_rdata,
  input  logic          ls_valid,
  output logic          ls_ready,
  input  logic          ls_cp,
  input  logic          ls_store,
  input  logic          ls_long,
  input  logic [AW-1:0] ls_idx,
  input  logic [DW-1:0] ls_wdata,
  output logic [DW-1:0] ls_rdata,
  output logic          ls_cant,
  input  logic          dp_valid,
  input  logic          dp_cp,
  input  logic [3:0]    dp_op,
  input  logic [AW-1:0] dp_src,
  output logic [1:0]    dp_resp,
  output logic          fiq_n,
  output logic          irq_n
);
  import tcp_pkg::*;

  localparam int NLINE = 2;

  logic [DW-1:0] src_val;
  logic [DW-1:0] stamp;
  logic          beat_q;
  logic [AW-1:0] ls_eff;
  logic          stall_req, stall_busy, stall_active;
  logic          reject, free;
  logic          do_stamp;
  logic          load_we;
  logic [NLINE-1:0] l_sched, l_clr, l_n;
  rsp_e          rsp;

  assign rt_ready = 1'b1;
  assign ls_ready = 1'b1;

  assign ls_eff  = ls_idx + AW'(beat_q);
  assign ls_cant = ls_valid && ls_cp;
  assign load_we = ls_valid && !ls_cp && !ls_store;

  always_ff @(posedge clk) begin
    if (!rst_n)                 beat_q <= 1'b0;
    else if (ls_valid && !ls_cp) beat_q <= ls_long ? ~beat_q : 1'b0;
  end

  assign reject    = dp_cp ? (dp_op > OP_LAST) : (dp_op != OP_STALL);
  assign stall_req = dp_valid && (dp_op == OP_STALL);
  assign free      = dp_valid && dp_cp && !reject && !stall_active;
  assign do_stamp  = free && (dp_op == OP_STAMP);

  always_comb begin
    if (!dp_valid)      rsp = RSP_IDLE;
    else if (reject)    rsp = RSP_CANT;
    else if (stall_busy) rsp = RSP_BUSY;
    else                rsp = RSP_DONE;
  end
  assign dp_resp = rsp;

  tcp_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we_a(do_stamp), .idx_a(dp_src), .d_a(stamp),
    .we_b(rt_valid && rt_write), .idx_b(rt_idx), .d_b(rt_wdata),
    .we_c(load_we), .idx_c(ls_eff), .d_c(ls_wdata),
    .rd_idx0(rt_idx), .rd_dat0(rt_rdata),
    .rd_idx1(ls_eff), .rd_dat1(ls_rdata),
    .rd_idx2(dp_src), .rd_dat2(src_val)
  );

  tcp_stall #(.CW(DW)) u_stall (
    .clk(clk), .rst_n(rst_n), .req(stall_req), .count(src_val),
    .busy(stall_busy), .active(stall_active)
  );

  tcp_cycle_ctr #(.CW(DW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .count(stamp)
  );

  // line 0 is FIQ, line 1 is IRQ; set and clear codes step by one per line
  for (genvar k = 0; k < NLINE; k++) begin : g_line
    assign l_sched[k] = free && (dp_op == OP_FIQ_SET + 4'(k));
    assign l_clr[k]   = free && (dp_op == OP_FIQ_CLR + 4'(k));
    tcp_line_sched #(.CW(DW)) u_ls (
      .clk(clk), .rst_n(rst_n), .sched(l_sched[k]), .clr(l_clr[k]),
      .delay(src_val), .line_n(l_n[k])
    );
  end

  assign fiq_n = l_n[0];
  assign irq_n = l_n[1];

  // R5: a rejected request leaves both lines untouched in the next cycle
  assert_reject_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && reject) |-> (l_sched == '0 && l_clr == '0 && !do_stamp));
  // R12: idle answer exactly when no request
  assert_idle_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_valid |-> dp_resp == 2'd3);
endmodule

// File: tb/sim_test_copro.sv
module sim_test_copro;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        rt_valid = 0, rt_write = 0;
  logic [3:0]  rt_idx = 0;
  logic [31:0] rt_wdata = 0;
  logic        ls_valid = 0, ls_cp = 0, ls_store = 0, ls_long = 0;
  logic [3:0]  ls_idx = 0;
  logic [31:0] ls_wdata = 0;
  logic        dp_valid = 0, dp_cp = 0;
  logic [3:0]  dp_op = 0, dp_src = 0;
  logic        rt_ready, ls_ready, ls_cant, fiq_n, irq_n;
  logic [31:0] rt_rdata, ls_rdata;
  logic [1:0]  dp_resp;

  test_copro u0 (.*);

  int errors = 0, checks = 0;
  string tag = "R1";
  logic [31:0] m_regs [16];
  logic [31:0] m_cnt;
  int m_active, m_beat;
  logic [31:0] m_rem;
  int m_pend [2], m_lvl [2];
  logic [31:0] m_left [2];
  logic [1:0] last_resp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    rt_valid = 0; rt_write = 0; ls_valid = 0; ls_long = 0; ls_store = 0; ls_cp = 0;
    dp_valid = 0; dp_cp = 0; dp_op = 0; dp_src = 0;
  endtask

  task automatic cyc();
    logic [31:0] nr [16];
    int rej, free_op;
    logic [31:0] n, v;
    logic [1:0] er;
    #1;
    rej = dp_cp ? (dp_op > 5) : (dp_op != 0);
    if (!dp_valid) er = 2'd3;
    else if (rej) er = 2'd2;
    else if (dp_op == 0) begin
      n = m_regs[dp_src];
      er = (m_active != 0) ? ((m_rem != 0) ? 2'd1 : 2'd0) : ((n != 0) ? 2'd1 : 2'd0);
    end else er = 2'd0;
    last_resp = dp_resp;
    chk({tag, "/R12 resp"}, {30'd0, dp_resp}, {30'd0, er});
    chk({tag, " fiq_n"}, {31'd0, fiq_n}, m_lvl[0]);
    chk({tag, " irq_n"}, {31'd0, irq_n}, m_lvl[1]);
    chk({tag, "/R3 ls_cant"}, {31'd0, ls_cant}, {31'd0, ls_valid && ls_cp});
    if (rt_valid && !rt_write) chk({tag, " rt_rdata"}, rt_rdata, m_regs[rt_idx]);
    if (ls_valid && ls_store && !ls_cp) chk({tag, " ls_rdata"}, ls_rdata, m_regs[4'(ls_idx + m_beat)]);
    // model update
    foreach (nr[i]) nr[i] = m_regs[i];
    if (ls_valid && !ls_cp && !ls_store) nr[4'(ls_idx + m_beat)] = ls_wdata;
    if (rt_valid && rt_write) nr[rt_idx] = rt_wdata;
    free_op = dp_valid && dp_cp && !rej && (m_active == 0);
    if (free_op && dp_op == 5) nr[dp_src] = m_cnt;
    for (int k = 0; k < 2; k++) begin
      v = m_regs[dp_src];
      if (free_op && dp_op == 3 + k) begin m_lvl[k] = 1; m_pend[k] = 0; end
      else if (free_op && dp_op == 1 + k) begin
        if (v == 0) begin m_lvl[k] = 0; m_pend[k] = 0; end
        else begin m_pend[k] = 1; m_left[k] = v - 1; end
      end else if (m_pend[k] != 0) begin
        if (m_left[k] == 0) begin m_lvl[k] = 0; m_pend[k] = 0; end
        else m_left[k] = m_left[k] - 1;
      end
    end
    if (!(dp_valid && dp_op == 0)) m_active = 0;
    else if (m_active == 0) begin
      if (m_regs[dp_src] != 0) begin m_active = 1; m_rem = m_regs[dp_src] - 1; end
    end else if (m_rem == 0) m_active = 0;
    else m_rem = m_rem - 1;
    if (ls_valid && !ls_cp) m_beat = ls_long ? (m_beat ^ 1) : 0;
    m_cnt = m_cnt + 1;
    foreach (nr[i]) m_regs[i] = nr[i];
    @(negedge clk);
  endtask

  task automatic rt_wr(input logic [3:0] i, input logic [31:0] d);
    idle(); rt_valid = 1; rt_write = 1; rt_idx = i; rt_wdata = d; cyc(); idle();
  endtask
  task automatic rt_rd(input logic [3:0] i);
    idle(); rt_valid = 1; rt_idx = i; cyc(); idle();
  endtask
  task automatic dp_pulse(input logic cp, input logic [3:0] op, input logic [3:0] s);
    idle(); dp_valid = 1; dp_cp = cp; dp_op = op; dp_src = s; cyc(); idle();
  endtask
  task automatic stall(input logic cp, input logic [3:0] s, input int n);
    int busy_cycles = 0;
    idle(); dp_valid = 1; dp_cp = cp; dp_op = 0; dp_src = s;
    for (int t = 0; t < 60; t++) begin
      cyc();
      if (last_resp == 2'd1) busy_cycles++;
      else break;
    end
    idle(); cyc();
    chk("R4 busy count", busy_cycles, n);
  endtask
  task automatic gap(input int n);
    idle(); for (int t = 0; t < n; t++) cyc();
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (m_regs[i]) m_regs[i] = 0;
    m_cnt = 0; m_active = 0; m_rem = 0; m_beat = 0;
    for (int k = 0; k < 2; k++) begin m_pend[k] = 0; m_lvl[k] = 1; m_left[k] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 fiq_n reset", {31'd0, fiq_n}, 1);
    chk("R1 irq_n reset", {31'd0, irq_n}, 1);
    chk("R12 idle reset", {30'd0, dp_resp}, 3);
    rst_n = 1;
    tag = "R1";
    for (int i = 0; i < 16; i++) rt_rd(4'(i));
    tag = "R2";
    rt_wr(1, 32'hDEAD_BEEF); rt_wr(15, 32'h1234_5678); rt_rd(1); rt_rd(15);
    tag = "R3";
    idle(); ls_valid = 1; ls_idx = 6; ls_wdata = 32'hAAAA_0006; cyc();
    idle(); ls_valid = 1; ls_long = 1; ls_idx = 15; ls_wdata = 32'h0000_00F0; cyc();
    ls_valid = 1; ls_long = 1; ls_idx = 15; ls_wdata = 32'h0000_0F00; cyc();
    rt_rd(15); rt_rd(0);
    idle(); ls_valid = 1; ls_store = 1; ls_long = 1; ls_idx = 15; cyc();
    ls_valid = 1; ls_store = 1; ls_long = 1; ls_idx = 15; cyc();
    idle(); ls_valid = 1; ls_cp = 1; ls_idx = 6; ls_wdata = 32'h5555_5555; cyc();
    rt_rd(6);
    tag = "R4";
    rt_wr(2, 5); rt_wr(3, 0); rt_wr(4, 1);
    stall(0, 2, 5); stall(1, 3, 0); stall(1, 4, 1);
    tag = "R5";
    dp_pulse(0, 3, 2); dp_pulse(0, 1, 3); dp_pulse(1, 6, 3); dp_pulse(1, 15, 3); dp_pulse(0, 5, 9);
    gap(3); rt_rd(9);
    tag = "R6";
    rt_wr(5, 3);
    dp_pulse(1, 1, 5); gap(6);
    dp_pulse(1, 2, 3); gap(2);
    tag = "R8";
    dp_pulse(1, 3, 0); dp_pulse(1, 4, 0); gap(2);
    tag = "R7";
    rt_wr(10, 10);
    dp_pulse(1, 1, 10); gap(2); dp_pulse(1, 1, 4); gap(12);
    dp_pulse(1, 3, 0);
    tag = "R8";
    dp_pulse(1, 2, 5); gap(1); dp_pulse(1, 4, 0); gap(8);
    tag = "R9";
    dp_pulse(1, 5, 7); gap(4); dp_pulse(1, 5, 8); rt_rd(7); rt_rd(8);
    tag = "R10";
    chk("R10 stamp distance", m_regs[8] - m_regs[7], 5);
    tag = "R11";
    idle(); dp_valid = 1; dp_cp = 1; dp_op = 5; dp_src = 11;
    rt_valid = 1; rt_write = 1; rt_idx = 11; rt_wdata = 32'h1111_1111;
    ls_valid = 1; ls_idx = 11; ls_wdata = 32'h2222_2222; cyc();
    idle(); rt_valid = 1; rt_write = 1; rt_idx = 12; rt_wdata = 32'h3333_3333;
    ls_valid = 1; ls_idx = 12; ls_wdata = 32'h4444_4444; cyc();
    rt_rd(11); rt_rd(12);
    gap(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule